// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop is in lock. It runs on a fast sampling clock and receives two single-cycle pulses: one marks each reference edge and the other each edge of the divided VCO. For every pair of edges a counter measures the gap between the two pulses. The gap is then compared with a timing window around the reference edge. The window length is set in fast-clock cycles. The window can be symmetric, which accepts early or late VCO arrival. It can also be one-sided, which accepts only a delayed VCO or only an advanced VCO.

A run of consecutive in-window arrivals raises the lock flag. The required length of the run is programmable. One out-of-window arrival clears the flag at once, and a new run must then be counted from zero. The flag is always visible on a read-only status bit. It can also be routed to a shared output pin. While a serial read is in progress, that pin carries serial read data instead of the flag.

Top module: `pll_lock_detect`

## Requirements
- R1: While `lkd_en_i` is low, and after reset, `lock_o` is 0, the consecutive-hit count is 0 and no measurement is in progress.
- R2: With `asym_en_i` = 0 (symmetric window of W = `win_len_i` cycles), a pair whose VCO pulse lands at most W cycles before or after the reference pulse is a hit. A larger gap is a miss. Pulses sampled on the same edge have gap 0 and are a hit in every mode.
- R3: With `asym_en_i` = 1 and `asym_late_i` = 1 (delay-only window), a hit requires the VCO pulse to arrive 0 to W cycles after the reference pulse. Any VCO pulse that leads the reference is a miss.
- R4: With `asym_en_i` = 1 and `asym_late_i` = 0 (advance-only window), a hit requires the VCO pulse to arrive 0 to W cycles before the reference pulse. Any VCO pulse that trails the reference is a miss.
- R5: `lock_o` rises on the clock edge that samples the closing pulse of the Nth consecutive hit, where N = `run_len_i`. It does not rise earlier.
- R6: A miss clears `lock_o` on the edge that detects it. Lock then needs N new consecutive hits.
- R7: A measurement that sees no closing pulse within 2W cycles of its opening pulse ends as a miss. A second pulse of the same kind as the opening pulse, arriving before the measurement closes, is also a miss.
- R8: The hit count saturates at `run_len_i`. Further hits keep `lock_o` high.
- R9: `pin_o` equals `sread_data_i` while `sread_active_i` is 1. Otherwise it equals `lock_o` when `pin_oe_i` is 1, and 0 when `pin_oe_i` is 0.
- R10: `stat_lock_o` always equals `lock_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| lkd_en_i | input | 1 | Lock-detect enable |
| win_len_i | input | CNT_W | Window length W in clock cycles |
| run_len_i | input | RUN_W | Consecutive hits required for lock |
| asym_en_i | input | 1 | 1 selects a one-sided window |
| asym_late_i | input | 1 | One-sided side: 1 delay-only, 0 advance-only |
| pin_oe_i | input | 1 | Route lock flag to the shared pin |
| ref_pulse_i | input | 1 | Single-cycle reference edge marker |
| vco_pulse_i | input | 1 | Single-cycle divided-VCO edge marker |
| sread_active_i | input | 1 | Serial read in progress |
| sread_data_i | input | 1 | Serial read data bit |
| lock_o | output | 1 | Lock flag |
| stat_lock_o | output | 1 | Read-only status copy of the lock flag |
| pin_o | output | 1 | Shared pin: lock flag or serial data |

## Verification
The assertions assume the following about the inputs:
- Pulses are single-cycle markers.
- Window length, run length and window mode change only while the block is disabled.
- The run length is at least one.

The bench keeps within these limits. It changes configuration only while enable is low, and it draws window and run lengths from ranges that start at one. It spaces each pulse pair by at least 2W+4 idle cycles, so every measurement, including one left open after a timeout, closes before the next pair begins.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
    typedef enum logic [1:0] {
        MS_IDLE     = 2'd0,
        MS_REF_LEAD = 2'd1,
        MS_VCO_LEAD = 2'd2
    } meas_state_e;
endpackage

// File: rtl/lkd_window_meas.sv
module lkd_window_meas
    import lkd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             en_i,
    input  logic             ref_pulse_i,
    input  logic             vco_pulse_i,
    input  logic [CNT_W-1:0] win_len_i,
    input  logic             asym_en_i,
    input  logic             asym_late_i,
    output logic             hit_o,
    output logic             miss_o
);
    localparam int GAP_W = CNT_W + 1;
    localparam logic [GAP_W-1:0] ONE = {{(GAP_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        meas_state_e      state;
        logic [GAP_W-1:0] gap;
    } meas_t;

    meas_t cur_q, nxt_d;
    logic [GAP_W-1:0] win_ext;
    logic [GAP_W-1:0] limit;
    logic             allow_late;
    logic             allow_early;

    always_comb begin
        win_ext     = {1'b0, win_len_i};
        limit       = {win_len_i, 1'b0};
        allow_late  = !asym_en_i || asym_late_i;
        allow_early = !asym_en_i || !asym_late_i;
        nxt_d       = cur_q;
        hit_o       = 1'b0;
        miss_o      = 1'b0;
        if (!en_i) begin
            nxt_d.state = MS_IDLE;
            nxt_d.gap   = '0;
        end else begin
            unique case (cur_q.state)
                MS_IDLE: begin
                    if (ref_pulse_i && vco_pulse_i) begin
                        hit_o = 1'b1;
                    end else if (ref_pulse_i) begin
                        nxt_d.state = MS_REF_LEAD;
                        nxt_d.gap   = ONE;
                    end else if (vco_pulse_i) begin
                        nxt_d.state = MS_VCO_LEAD;
                        nxt_d.gap   = ONE;
                    end
                end
                MS_REF_LEAD: begin
                    if (vco_pulse_i) begin
                        hit_o  = allow_late && (cur_q.gap <= win_ext);
                        miss_o = !(allow_late && (cur_q.gap <= win_ext));
                        if (ref_pulse_i) begin
                            nxt_d.gap = ONE;
                        end else begin
                            nxt_d.state = MS_IDLE;
                            nxt_d.gap   = '0;
                        end
                    end else if (ref_pulse_i) begin
                        miss_o    = 1'b1;
                        nxt_d.gap = ONE;
                    end else if (cur_q.gap >= limit) begin
                        miss_o      = 1'b1;
                        nxt_d.state = MS_IDLE;
                        nxt_d.gap   = '0;
                    end else begin
                        nxt_d.gap = cur_q.gap + ONE;
                    end
                end
                MS_VCO_LEAD: begin
                    if (ref_pulse_i) begin
                        hit_o  = allow_early && (cur_q.gap <= win_ext);
                        miss_o = !(allow_early && (cur_q.gap <= win_ext));
                        if (vco_pulse_i) begin
                            nxt_d.gap = ONE;
                        end else begin
                            nxt_d.state = MS_IDLE;
                            nxt_d.gap   = '0;
                        end
                    end else if (vco_pulse_i) begin
                        miss_o    = 1'b1;
                        nxt_d.gap = ONE;
                    end else if (cur_q.gap >= limit) begin
                        miss_o      = 1'b1;
                        nxt_d.state = MS_IDLE;
                        nxt_d.gap   = '0;
                    end else begin
                        nxt_d.gap = cur_q.gap + ONE;
                    end
                end
                default: begin
                    nxt_d.state = MS_IDLE;
                    nxt_d.gap   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            cur_q.state <= MS_IDLE;
            cur_q.gap   <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/lkd_run_tracker.sv
module lkd_run_tracker #(
    parameter int RUN_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             en_i,
    input  logic             hit_i,
    input  logic             miss_i,
    input  logic [RUN_W-1:0] run_len_i,
    output logic             lock_o,
    output logic [RUN_W-1:0] run_o
);
    localparam logic [RUN_W-1:0] INC = {{(RUN_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             lock;
    } trk_t;

    trk_t cur_q, nxt_d;
    logic [RUN_W-1:0] run_inc;

    always_comb begin
        nxt_d   = cur_q;
        run_inc = (cur_q.run >= run_len_i) ? run_len_i : cur_q.run + INC;
        if (!en_i || miss_i) begin
            nxt_d.run  = '0;
            nxt_d.lock = 1'b0;
        end else if (hit_i) begin
            nxt_d.run  = run_inc;
            nxt_d.lock = (run_inc >= run_len_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            cur_q.run  <= '0;
            cur_q.lock <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign lock_o = cur_q.lock;
    assign run_o  = cur_q.run;
endmodule

// File: rtl/lkd_pin_share.sv
module lkd_pin_share (
    input  logic lock_i,
    input  logic oe_i,
    input  logic sread_active_i,
    input  logic sread_data_i,
    output logic pin_o
);
    always_comb begin
        if (sread_active_i) begin
            pin_o = sread_data_i;
        end else if (oe_i) begin
            pin_o = lock_i;
        end else begin
            pin_o = 1'b0;
        end
    end
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
    parameter int CNT_W = 8,
    parameter int RUN_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             lkd_en_i,
    input  logic [CNT_W-1:0] win_len_i,
    input  logic [RUN_W-1:0] run_len_i,
    input  logic             asym_en_i,
    input  logic             asym_late_i,
    input  logic             pin_oe_i,
    input  logic             ref_pulse_i,
    input  logic             vco_pulse_i,
    input  logic             sread_active_i,
    input  logic             sread_data_i,
    output logic             lock_o,
    output logic             stat_lock_o,
    output logic             pin_o
);
    logic             meas_hit;
    logic             meas_miss;
    logic             lock_flag;
    logic [RUN_W-1:0] run_cnt;

    lkd_window_meas #(.CNT_W(CNT_W)) meas_i (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .en_i        (lkd_en_i),
        .ref_pulse_i (ref_pulse_i),
        .vco_pulse_i (vco_pulse_i),
        .win_len_i   (win_len_i),
        .asym_en_i   (asym_en_i),
        .asym_late_i (asym_late_i),
        .hit_o       (meas_hit),
        .miss_o      (meas_miss)
    );

    lkd_run_tracker #(.RUN_W(RUN_W)) trk_i (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .en_i      (lkd_en_i),
        .hit_i     (meas_hit),
        .miss_i    (meas_miss),
        .run_len_i (run_len_i),
        .lock_o    (lock_flag),
        .run_o     (run_cnt)
    );

    lkd_pin_share pin_i (
        .lock_i         (lock_flag),
        .oe_i           (pin_oe_i),
        .sread_active_i (sread_active_i),
        .sread_data_i   (sread_data_i),
        .pin_o          (pin_o)
    );

    assign lock_o      = lock_flag;
    assign stat_lock_o = lock_flag;
endmodule

// File: rtl/lkd_checker.sv
module lkd_checker #(
    parameter int RUN_W = 12
) (
    input logic             clk_i,
    input logic             rst_n_i,
    input logic             lkd_en_i,
    input logic [RUN_W-1:0] run_len_i,
    input logic             sread_active_i,
    input logic             sread_data_i,
    input logic             lock_i,
    input logic             stat_i,
    input logic             pin_i,
    input logic             hit_i,
    input logic             miss_i,
    input logic [RUN_W-1:0] run_i
);
    assert_disable_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !lkd_en_i |=> (!lock_i && (run_i == '0)));

    assert_lock_needs_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(lock_i) |-> $past(hit_i));

    assert_miss_drops_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (lkd_en_i && miss_i) |=> (!lock_i && (run_i == '0)));

    assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        run_i <= run_len_i);

    assert_pin_read_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        sread_active_i |-> (pin_i == sread_data_i));

    assert_status_mirror_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        stat_i == lock_i);
endmodule

bind pll_lock_detect lkd_checker #(.RUN_W(RUN_W)) chk_i (
    .clk_i          (clk_i),
    .rst_n_i        (rst_n_i),
    .lkd_en_i       (lkd_en_i),
    .run_len_i      (run_len_i),
    .sread_active_i (sread_active_i),
    .sread_data_i   (sread_data_i),
    .lock_i         (lock_o),
    .stat_i         (stat_lock_o),
    .pin_i          (pin_o),
    .hit_i          (meas_hit),
    .miss_i         (meas_miss),
    .run_i          (run_cnt)
);

// File: tb/pll_lock_detect_tb_top.sv
module pll_lock_detect_tb_top;
    localparam int CNT_W = 8;
    localparam int RUN_W = 12;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             lkd_en;
    logic [CNT_W-1:0] win_len;
    logic [RUN_W-1:0] run_len;
    logic             asym_en, asym_late, pin_oe;
    logic             ref_p, vco_p, sr_act, sr_dat;
    logic             lock, stat, pin;

    int  checks = 0;
    int  fails = 0;
    bit  done = 0;
    int  exp_run = 0;
    bit  exp_lock = 0;
    int  cur_w = 4;
    int  cur_l = 3;

    always #2 clk = ~clk;

    pll_lock_detect #(.CNT_W(CNT_W), .RUN_W(RUN_W)) dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .lkd_en_i(lkd_en), .win_len_i(win_len),
        .run_len_i(run_len), .asym_en_i(asym_en), .asym_late_i(asym_late),
        .pin_oe_i(pin_oe), .ref_pulse_i(ref_p), .vco_pulse_i(vco_p),
        .sread_active_i(sr_act), .sread_data_i(sr_dat),
        .lock_o(lock), .stat_lock_o(stat), .pin_o(pin)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_hit(input int g, input int w, input bit ae, input bit late);
        if (g == 0) return 1'b1;
        if (g > 0) return (g <= w) && (!ae || late);
        return (-g <= w) && (!ae || !late);
    endfunction

    function automatic bit exp_pin(input bit act, input bit dat, input bit oe, input bit lk);
        if (act) return dat;
        if (oe) return lk;
        return 1'b0;
    endfunction

    task automatic model(input bit h);
        if (h) begin
            exp_run = (exp_run >= cur_l) ? cur_l : exp_run + 1;
            exp_lock = (exp_run >= cur_l);
        end else begin
            exp_run = 0;
            exp_lock = 0;
        end
    endtask

    task automatic configure(input int w, input int l, input bit ae, input bit late);
        lkd_en = 1'b0;
        tick();
        chk("R1 disable clears lock", lock, 0);
        win_len = CNT_W'(w);
        run_len = RUN_W'(l);
        asym_en = ae;
        asym_late = late;
        cur_w = w;
        cur_l = l;
        exp_run = 0;
        exp_lock = 0;
        tick();
        lkd_en = 1'b1;
        tick();
    endtask

    // Drive one pulse pair with gap g (positive: VCO after reference).
    task automatic send_pair(input int g);
        if (g == 0) begin
            ref_p = 1'b1; vco_p = 1'b1;
            tick();
            ref_p = 1'b0; vco_p = 1'b0;
        end else if (g > 0) begin
            ref_p = 1'b1; tick(); ref_p = 1'b0;
            repeat (g - 1) tick();
            vco_p = 1'b1; tick(); vco_p = 1'b0;
        end else begin
            vco_p = 1'b1; tick(); vco_p = 1'b0;
            repeat (-g - 1) tick();
            ref_p = 1'b1; tick(); ref_p = 1'b0;
        end
    endtask

    task automatic episode(input int g, input string req);
        bit h;
        send_pair(g);
        h = exp_hit(g, cur_w, asym_en, asym_late);
        model(h);
        repeat (2 * cur_w + 4) tick();
        chk(req, lock, exp_lock);
        sr_act = 1'($urandom_range(0, 1));
        sr_dat = 1'($urandom_range(0, 1));
        pin_oe = 1'($urandom_range(0, 1));
        #1;
        chk("R9 pin select", pin, exp_pin(sr_act, sr_dat, pin_oe, exp_lock));
        chk("R10 status mirror", stat, lock);
        sr_act = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; lkd_en = 1'b0; win_len = 8'd4; run_len = 12'd3;
        asym_en = 1'b0; asym_late = 1'b0; pin_oe = 1'b1;
        ref_p = 1'b0; vco_p = 1'b0; sr_act = 1'b0; sr_dat = 1'b0;
        repeat (3) tick();
        chk("R1 reset lock", lock, 0);
        chk("R9 reset pin", pin, 0);
        rst_n = 1'b1;
        tick();

        // Directed: symmetric window edges and exact lock timing (R2, R5)
        configure(4, 3, 1'b0, 1'b0);
        episode(4, "R2 late edge hit");
        episode(-4, "R2 early edge hit");
        send_pair(0);
        model(1'b1);
        chk("R5 lock on Nth hit edge", lock, 1);
        repeat (12) tick();
        episode(2, "R8 saturated stays locked");
        episode(-1, "R8 saturated stays locked");
        // Single miss at gap W+1, detected on the closing edge (R6)
        send_pair(5);
        model(1'b0);
        chk("R6 miss clears at once", lock, 0);
        repeat (12) tick();
        episode(1, "R6 restart from zero");
        episode(1, "R6 restart from zero");
        episode(1, "R6 relock after full run");
        chk("R6 relock value", lock, 1);

        // Duplicate reference before closing is a miss (R7)
        ref_p = 1'b1; tick(); ref_p = 1'b0; tick();
        ref_p = 1'b1; tick(); ref_p = 1'b0;
        model(1'b0);
        chk("R7 repeated reference miss", lock, 0);
        repeat (12) tick();
        // Timeout with no VCO pulse
        episode(1, "R7 setup"); episode(1, "R7 setup"); episode(1, "R7 setup");
        ref_p = 1'b1; tick(); ref_p = 1'b0;
        repeat (7) tick();
        chk("R7 before timeout", lock, 1);
        tick();
        model(1'b0);
        chk("R7 timeout miss", lock, 0);
        repeat (6) tick();

        // Disable clears (R1)
        episode(0, "R1 setup"); episode(0, "R1 setup"); episode(0, "R1 setup");
        lkd_en = 1'b0; tick();
        chk("R1 disable clears lock", lock, 0);
        lkd_en = 1'b1; exp_run = 0; exp_lock = 0; tick();
        episode(0, "R1 count restarted");

        // One-sided windows (R3, R4)
        configure(3, 1, 1'b1, 1'b1);
        episode(3, "R3 delay-only late hit");
        episode(-1, "R3 delay-only early miss");
        episode(0, "R3 delay-only zero hit");
        configure(3, 1, 1'b1, 1'b0);
        episode(-3, "R4 advance-only early hit");
        episode(1, "R4 advance-only late miss");
        episode(0, "R4 advance-only zero hit");

        // Constrained random configurations and gaps
        for (int c = 0; c < 12; c++) begin
            int w;
            int l;
            bit ae;
            bit lt;
            w = $urandom_range(1, 8);
            l = $urandom_range(1, 6);
            ae = 1'($urandom_range(0, 1));
            lt = 1'($urandom_range(0, 1));
            configure(w, l, ae, lt);
            for (int e = 0; e < 30; e++) begin
                int g;
                if ($urandom_range(0, 9) < 7) g = $urandom_range(0, w);
                else g = $urandom_range(w + 1, 2 * w + 2);
                if ($urandom_range(0, 1) == 1) g = -g;
                if (!ae) episode(g, "R2 random symmetric");
                else if (lt) episode(g, "R3 random delay-only");
                else episode(g, "R4 random advance-only");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule